// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block stands between a bank of interrupt request lines and a single-issue CPU core. It owns the global interrupt enable flag. It latches request pulses into pending flags and chooses the most urgent request that is both pending and individually enabled. At an instruction boundary it stalls the core for a fixed four-cycle entry: it pushes the 16-bit return address onto a byte-wide stack, drops the global enable and then presents the handler's vector address.

The core reports each retiring instruction with `insn_done`. It raises `multi_busy` during every cycle of a multi-cycle instruction except the last one. The enable-set, enable-clear and return commands arrive as one-cycle strobes in the cycle their instruction retires. A return command pops the saved address in three cycles, hands it back to the core and sets the global enable again.

The stack port is a plain synchronous RAM port with no back-pressure. Each write completes in its own cycle. Read data appears on `stk_rdata` one cycle after `stk_re` is asserted. The block has no other data stream, so none of its pins use a valid/ready handshake.

Top module: `irq_entry_seq`

## Requirements
- R1: While the global enable `gie` is 0, no entry sequence starts, whatever `irq_en` and the pending flags hold. After reset `gie` is 0, `core_hold` is 0 and the stack pointer is `SP_TOP` (0xFF).
- R2: An entry starts only in a boundary cycle: `insn_done`=1, `multi_busy`=0, `gie`=1, no CLI or RETI strobe, and at least one bit set in pending AND `irq_en`. In cycles with `insn_done`=0 no entry starts.
- R3: An entry holds `core_hold` high for exactly 4 cycles, starting the cycle after acceptance. In entry cycle 1 it writes the low byte of `pc_in` (sampled at acceptance) to address SP. In cycle 2 it writes the high byte to SP-1. Cycle 3 is idle. In cycle 4 it raises `vec_valid`. SP ends 2 lower.
- R4: `gie` reads 0 from the first entry cycle onward.
- R5: Among the pending and enabled requests, the lowest index wins. `vec_addr` = `VEC_BASE` + 2*index, with `VEC_BASE` = 0x0002.
- R6: An `irq_req` bit pulse sets its pending flag. The flag is cleared in the cycle its vector is presented. Several pulses before service produce a single entry.
- R7: SEI sets `gie` from the next cycle. Acceptance uses the registered flag, so the instruction that retires after SEI always completes before any entry.
- R8: CLI clears `gie` from the next cycle and also blocks acceptance in its own cycle. When CLI and SEI arrive together, CLI wins.
- R9: A RETI strobe at a boundary holds the core for 3 cycles. It reads SP+1 (high byte) and then SP+2 (low byte). In the third cycle it raises `ret_valid` with `ret_addr` = {high, low}. `gie` is 1 in the following cycle, and SP ends 2 higher.
- R10: A boundary with `multi_busy`=1 does not start an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | N_IRQ | Request pulses, one bit per source |
| irq_en | input | N_IRQ | Individual enable bits |
| insn_done | input | 1 | An instruction retires this cycle |
| multi_busy | input | 1 | Multi-cycle instruction not yet in its last cycle |
| pc_in | input | 16 | Return address to save on entry |
| sei_i | input | 1 | Set-global-enable strobe |
| cli_i | input | 1 | Clear-global-enable strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| core_hold | output | 1 | Stall the core; a sequence is running |
| gie | output | 1 | Global interrupt enable flag |
| vec_valid | output | 1 | Vector address is presented this cycle |
| vec_addr | output | 16 | Handler vector address |
| ret_valid | output | 1 | Return address is presented this cycle |
| ret_addr | output | 16 | Popped return address |
| stk_we | output | 1 | Stack byte write |
| stk_re | output | 1 | Stack byte read |
| stk_addr | output | SP_W | Stack byte address |
| stk_wdata | output | 8 | Stack write data |
| stk_rdata | input | 8 | Stack read data, one cycle after `stk_re` |

## Verification
Most internal faults in this block show up at the ports within a few cycles. A corrupted sequencer state shows as a `core_hold` window that is not exactly four or three cycles long. It can also show as a stack write in the wrong entry cycle, or a `vec_valid` that comes without the two writes before it. A stack pointer that drifts shows as wrong `stk_addr` values in the very next push or pop, and as a wrong `ret_addr`. Stale or lost pending flags take longer to show. They appear one service later, as an extra entry or a missing one, or as a wrong vector index when the priority is compared against a model of the requests.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int PC_W = 16;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PUSH_LO,
    S_PUSH_HI,
    S_FILL,
    S_VECT,
    S_POP_HI,
    S_POP_LO,
    S_RET
  } seq_state_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] req_i,
  input  logic [N_IRQ-1:0] clr_i,
  output logic [N_IRQ-1:0] pend_o
);
  // one flag per source; a new pulse beats a clear in the same cycle
  for (genvar g = 0; g < N_IRQ; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk) begin
      if (!rst_n)         flag_q <= 1'b0;
      else if (req_i[g])  flag_q <= 1'b1;
      else if (clr_i[g])  flag_q <= 1'b0;
    end
    assign pend_o[g] = flag_q;
  end

  // R6: hardware only clears a flag that is actually set
  p_clear_only_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_i) |-> (|(clr_i & pend_o)));
  // R6: a clear without a new pulse drops the flag
  p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~req_i)) |=> ((pend_o & $past(clr_i & ~req_i)) == '0));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N_IRQ = 8,
  localparam int IW = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] cand_i,
  output logic             any_o,
  output logic [IW-1:0]    idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end

  // R5: winner is a candidate and no lower index is a candidate
  p_pick_lowest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> (cand_i[idx_o] && ((cand_i & ((N_IRQ'(1) << idx_o) - N_IRQ'(1))) == '0)));
  p_pick_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_i == '0) |-> !any_o);
endmodule

// File: rtl/irq_gie_ctl.sv
module irq_gie_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic sei_i,
  input  logic cli_i,
  input  logic take_i,
  input  logic restore_i,
  output logic gie_o
);
  logic gie_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    gie_q <= 1'b0;
    else if (take_i || cli_i)      gie_q <= 1'b0;
    else if (restore_i || sei_i)   gie_q <= 1'b1;
  end
  assign gie_o = gie_q;

  // R4: acceptance drops the flag
  p_take_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> !gie_o);
  // R8: clear command wins
  p_cli_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cli_i |=> !gie_o);
  // R9: return restores the flag
  p_restore_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_i && !take_i && !cli_i) |=> gie_o);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int                N_IRQ    = 8,
  parameter int                SP_W     = 8,
  parameter logic [SP_W-1:0]   SP_TOP   = '1,
  parameter logic [PC_W-1:0]   VEC_BASE = 16'h0002
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             insn_done,
  input  logic             multi_busy,
  input  logic [PC_W-1:0]  pc_in,
  input  logic             sei_i,
  input  logic             cli_i,
  input  logic             reti_i,
  output logic             core_hold,
  output logic             gie,
  output logic             vec_valid,
  output logic [PC_W-1:0]  vec_addr,
  output logic             ret_valid,
  output logic [PC_W-1:0]  ret_addr,
  output logic             stk_we,
  output logic             stk_re,
  output logic [SP_W-1:0]  stk_addr,
  output logic [7:0]       stk_wdata,
  input  logic [7:0]       stk_rdata
);
  localparam int IW = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

  seq_state_e        st_q, st_nx;
  logic [SP_W-1:0]   sp_q;
  logic [PC_W-1:0]   pc_q;
  logic [IW-1:0]     win_q, win_idx;
  logic [7:0]        hi_q;
  logic [N_IRQ-1:0]  pend, clr_oh;
  logic              any_cand, boundary, take, start_ret, idle;

  assign idle      = (st_q == S_IDLE);
  assign boundary  = insn_done && !multi_busy;
  assign take      = idle && boundary && gie && any_cand && !cli_i && !reti_i;
  assign start_ret = idle && boundary && reti_i;
  assign clr_oh    = (st_q == S_VECT) ? (N_IRQ'(1) << win_q) : '0;

  irq_pend_bank #(.N_IRQ(N_IRQ)) u_pend (
    .clk(clk), .rst_n(rst_n), .req_i(irq_req), .clr_i(clr_oh), .pend_o(pend)
  );

  irq_prio_pick #(.N_IRQ(N_IRQ)) u_pick (
    .clk(clk), .rst_n(rst_n), .cand_i(pend & irq_en), .any_o(any_cand), .idx_o(win_idx)
  );

  irq_gie_ctl u_gie (
    .clk(clk), .rst_n(rst_n),
    .sei_i(idle && sei_i), .cli_i(idle && cli_i),
    .take_i(take), .restore_i(st_q == S_RET),
    .gie_o(gie)
  );

  always_comb begin
    st_nx = st_q;
    unique case (st_q)
      S_IDLE:    if (take) st_nx = S_PUSH_LO;
                 else if (start_ret) st_nx = S_POP_HI;
      S_PUSH_LO: st_nx = S_PUSH_HI;
      S_PUSH_HI: st_nx = S_FILL;
      S_FILL:    st_nx = S_VECT;
      S_VECT:    st_nx = S_IDLE;
      S_POP_HI:  st_nx = S_POP_LO;
      S_POP_LO:  st_nx = S_RET;
      S_RET:     st_nx = S_IDLE;
      default:   st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      sp_q  <= SP_TOP;
      pc_q  <= '0;
      win_q <= '0;
      hi_q  <= '0;
    end else begin
      st_q <= st_nx;
      case (st_q)
        S_IDLE: if (take) begin
          pc_q  <= pc_in;
          win_q <= win_idx;
        end
        S_PUSH_LO, S_PUSH_HI: sp_q <= sp_q - 1'b1;
        S_POP_HI: sp_q <= sp_q + 1'b1;
        S_POP_LO: begin
          sp_q <= sp_q + 1'b1;
          hi_q <= stk_rdata;
        end
        default: ;
      endcase
    end
  end

  assign core_hold = !idle;
  assign stk_we    = (st_q == S_PUSH_LO) || (st_q == S_PUSH_HI);
  assign stk_re    = (st_q == S_POP_HI) || (st_q == S_POP_LO);
  assign stk_addr  = stk_re ? (sp_q + 1'b1) : sp_q;
  assign stk_wdata = (st_q == S_PUSH_HI) ? pc_q[15:8] : pc_q[7:0];
  assign vec_valid = (st_q == S_VECT);
  assign vec_addr  = VEC_BASE + (PC_W'(win_q) << 1);
  assign ret_valid = (st_q == S_RET);
  assign ret_addr  = {hi_q, stk_rdata};

  // R1: no push can follow an idle cycle with the flag clear
  p_gie_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !gie) |=> !stk_we);
  // R10: busy boundary never starts an entry
  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && multi_busy) |=> !stk_we);
  // R2: no entry outside a boundary
  p_boundary_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !insn_done) |=> !core_hold || stk_re);
  // R3: two consecutive writes to descending addresses
  p_push_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_we && !$past(stk_we)) |=> (stk_we && stk_addr == $past(stk_addr) - 1'b1));
  // R3: vector comes two cycles after the last push
  p_vec_after_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ($past(stk_we, 2) && !$past(stk_we, 1) && core_hold));
  // R4: flag is low when the vector is shown
  p_vec_gie_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> !gie);
  // R7: enable takes effect next cycle, no entry yet
  p_sei_defer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && sei_i && !cli_i && !gie) |=> (gie && !stk_we));
  // R9: pops read ascending addresses, flag back afterwards
  p_pop_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_re && !$past(stk_re)) |=> (stk_re && stk_addr == $past(stk_addr) + 1'b1));
  p_ret_gie_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> (gie && !core_hold));
endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_req = '0, irq_en = '0;
  logic insn_done = 1'b0, multi_busy = 1'b0;
  logic [15:0] pc_in = '0;
  logic sei_i = 1'b0, cli_i = 1'b0, reti_i = 1'b0;
  logic core_hold, gie, vec_valid, ret_valid, stk_we, stk_re;
  logic [15:0] vec_addr, ret_addr;
  logic [7:0] stk_addr, stk_wdata, stk_rdata;

  logic [7:0] mem [256];
  logic [7:0] rd_q = '0;
  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] sp_m = 8'hFF;
  logic [N-1:0] pm = '0;

  always #2.5 clk = ~clk;

  irq_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
    .insn_done(insn_done), .multi_busy(multi_busy), .pc_in(pc_in),
    .sei_i(sei_i), .cli_i(cli_i), .reti_i(reti_i),
    .core_hold(core_hold), .gie(gie), .vec_valid(vec_valid), .vec_addr(vec_addr),
    .ret_valid(ret_valid), .ret_addr(ret_addr), .stk_we(stk_we), .stk_re(stk_re),
    .stk_addr(stk_addr), .stk_wdata(stk_wdata), .stk_rdata(stk_rdata)
  );

  always @(posedge clk) begin
    if (stk_we) mem[stk_addr] <= stk_wdata;
    if (stk_re) rd_q <= mem[stk_addr];
  end
  assign stk_rdata = rd_q;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  function automatic int lowest(input logic [N-1:0] m);
    for (int i = N - 1; i >= 0; i--) if (m[i]) lowest = i;
  endfunction

  task automatic pulse_req(input logic [N-1:0] m);
    irq_req = m; cyc(); irq_req = '0;
    pm |= m;
  endtask

  task automatic bnd(input logic s, input logic c, input logic r, input logic mb);
    insn_done = 1'b1; sei_i = s; cli_i = c; reti_i = r; multi_busy = mb;
    cyc();
    insn_done = 1'b0; sei_i = 1'b0; cli_i = 1'b0; reti_i = 1'b0; multi_busy = 1'b0;
  endtask

  // boundary that must start an entry for index idx; checks R3, R4, R5, R6
  task automatic do_entry(input logic [15:0] pc, input int idx);
    pc_in = pc;
    bnd(0, 0, 0, 0);
    chk(core_hold == 1'b1, "R3 hold entry c1", core_hold, 1);
    chk(stk_we && stk_addr == sp_m && stk_wdata == pc[7:0], "R3 push lo", {stk_addr, stk_wdata}, {sp_m, pc[7:0]});
    chk(gie == 1'b0, "R4 gie low", gie, 0);
    cyc();
    chk(stk_we && stk_addr == sp_m - 8'd1 && stk_wdata == pc[15:8], "R3 push hi", {stk_addr, stk_wdata}, {sp_m - 8'd1, pc[15:8]});
    cyc();
    chk(!stk_we && core_hold && !vec_valid, "R3 fill cycle", {stk_we, vec_valid}, 0);
    cyc();
    chk(vec_valid && vec_addr == 16'(2 + 2 * idx), "R5 vector", vec_addr, 2 + 2 * idx);
    cyc();
    chk(!core_hold && !vec_valid, "R3 hold released", core_hold, 0);
    sp_m = sp_m - 8'd2;
    pm[idx] = 1'b0;
  endtask

  task automatic do_reti(input logic [15:0] pc);
    bnd(0, 0, 1, 0);
    chk(stk_re && stk_addr == sp_m + 8'd1, "R9 pop hi addr", stk_addr, sp_m + 8'd1);
    cyc();
    chk(stk_re && stk_addr == sp_m + 8'd2, "R9 pop lo addr", stk_addr, sp_m + 8'd2);
    cyc();
    chk(ret_valid && ret_addr == pc, "R9 return addr", ret_addr, pc);
    cyc();
    chk(gie && !core_hold, "R9 gie restored", {gie, core_hold}, 2);
    sp_m = sp_m + 8'd2;
  endtask

  initial begin
    void'($urandom(32'h1CE5));
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    chk(!gie && !core_hold && !vec_valid && !stk_we, "R1 reset state", {gie, core_hold}, 0);

    // R1: flag clear blocks everything
    irq_en = '1;
    pulse_req(8'b0000_0100);
    for (int i = 0; i < 3; i++) begin
      bnd(0, 0, 0, 0);
      chk(!core_hold, "R1 no entry gie=0", core_hold, 0);
    end

    // R7: SEI boundary does not accept, next one does
    bnd(1, 0, 0, 0);
    chk(gie && !core_hold, "R7 after SEI", {gie, core_hold}, 2);
    do_entry(16'h1234, 2);
    do_reti(16'h1234);

    // R6: flag was cleared, nothing left
    bnd(0, 0, 0, 0);
    chk(!core_hold, "R6 flag cleared", core_hold, 0);

    // R8: CLI clears; R6 double pulse serviced once
    bnd(0, 1, 0, 0);
    chk(!gie, "R8 cli clears", gie, 0);
    pulse_req(8'b0000_0010);
    pulse_req(8'b0000_0010);
    bnd(1, 0, 0, 0);
    do_entry(16'hBEEF, 1);
    do_reti(16'hBEEF);
    bnd(0, 0, 0, 0);
    chk(!core_hold, "R6 merged pulses", core_hold, 0);

    // R5: masking and priority
    bnd(0, 1, 0, 0);
    pulse_req(8'b0000_1010);
    irq_en = 8'b1111_1101;
    bnd(1, 0, 0, 0);
    do_entry(16'h0A0B, 3);
    do_reti(16'h0A0B);
    irq_en = '1;
    do_entry(16'h0C0D, 1);
    do_reti(16'h0C0D);

    // R2: no entry without a boundary; R10: busy boundary blocks
    pulse_req(8'b0000_0001);
    repeat (3) begin
      cyc();
      chk(!core_hold, "R2 no boundary", core_hold, 0);
    end
    bnd(0, 0, 0, 1);
    chk(!core_hold, "R10 multi_busy", core_hold, 0);
    // R8: CLI blocks acceptance in its own cycle
    bnd(0, 1, 0, 0);
    chk(!core_hold && !gie, "R8 cli same cycle", {core_hold, gie}, 0);
    bnd(1, 1, 0, 0);
    chk(!gie, "R8 cli beats sei", gie, 0);
    bnd(1, 0, 0, 0);
    do_entry(16'h5566, 0);
    do_reti(16'h5566);
    bnd(0, 1, 0, 0);

    // random service rounds checked against the pending model
    for (int it = 0; it < 40; it++) begin
      logic [N-1:0] rq, en;
      logic [15:0] pc;
      rq = N'($urandom);
      en = N'($urandom);
      pc = 16'($urandom);
      if (rq != '0) pulse_req(rq);
      irq_en = en;
      cyc();
      if ((pm & en) != '0) begin
        bnd(1, 0, 0, 0);
        do_entry(pc, lowest(pm & en));
        do_reti(pc);
        bnd(0, 1, 0, 0);
      end else begin
        bnd(1, 0, 0, 0);
        bnd(0, 0, 0, 0);
        chk(!core_hold, "R5 nothing enabled", core_hold, 0);
        bnd(0, 1, 0, 0);
      end
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule